// File: doc/BRIEF.md
# Decode-Stage Fallback Branch Direction Predictor

This block sits right after instruction decode in a processor front-end. Each cycle it may receive one decoded instruction. The instruction arrives with a valid flag, a two-bit branch kind, its address, its length in bytes and its decoded target. It also arrives with a flag that says whether the earlier fetch-time dynamic predictor already produced a prediction for it. When that flag is set, the block leaves the instruction alone. When it is clear and the instruction is a branch, the block picks a direction from a fixed rule. The rule looks only at the branch kind and, for conditional branches, at whether the target lies below or above the branch.

A taken verdict is expensive. Fetch has already moved on along the sequential path, so the block issues a fetch redirect to the decoded target. In the same cycle it raises a flush on every front-end stage younger than the branch, and those stages drop their wrong-path contents. A not-taken verdict needs no action, because fetch has already continued sequentially. The block still reports the sequential address, computed as the branch address plus its length. All outputs are registered and appear one cycle after the instruction is presented. A configuration input switches off the backward-taken rule, so that every conditional branch defaults to not taken.

Top module: `static_dir_predictor`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, sp_valid, sp_taken, redirect_valid, redirect_pc, seq_pc and flush_stages are all zero.
- R2: A valid instruction of kind 2'b01 (unconditional direct), with dyn_hit low, gives sp_valid=1, sp_taken=1, redirect_valid=1 and redirect_pc equal to its target in the next cycle.
- R3: A valid instruction of kind 2'b10 (conditional direct), with dyn_hit low and a target strictly greater than its address (unsigned compare), gives sp_valid=1, sp_taken=0 and redirect_valid=0 in the next cycle.
- R4: A valid kind 2'b10 instruction, with dyn_hit low, bwd_rule_en high and a target less than or equal to its address, gives sp_taken=1, redirect_valid=1 and redirect_pc equal to its target in the next cycle. An equal target counts as backward.
- R5: A valid instruction of kind 2'b11 (indirect), with dyn_hit low, gives sp_valid=1, sp_taken=0 and redirect_valid=0 in the next cycle.
- R6: When dyn_hit is high, the next cycle has sp_valid=0, redirect_valid=0 and flush_stages=0, whatever the branch kind.
- R7: When dec_valid is low, or the kind is 2'b00 (not a branch), the next cycle has sp_valid=0, redirect_valid=0 and flush_stages=0.
- R8: flush_stages is all ones exactly in the cycles where redirect_valid is high, and zero otherwise. Both lines are high for only the one cycle after the branch that caused them.
- R9: With bwd_rule_en low, every kind 2'b10 instruction gives sp_taken=0 and redirect_valid=0, whatever its target.
- R10: One cycle after any instruction is presented, seq_pc equals its address plus its length, modulo 2^AW. redirect_pc is zero in every cycle where redirect_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_kind | input | 2 | 00 none, 01 unconditional direct, 10 conditional direct, 11 indirect |
| dec_pc | input | AW | Instruction address |
| dec_len | input | LW | Instruction length in bytes |
| dec_target | input | AW | Decoded branch target |
| dyn_hit | input | 1 | Dynamic predictor already predicted this instruction |
| bwd_rule_en | input | 1 | Enables the backward-taken rule for conditional branches |
| sp_valid | output | 1 | A static verdict was made |
| sp_taken | output | 1 | The static verdict is taken |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | AW | Redirect address |
| seq_pc | output | AW | Sequential next-instruction address |
| flush_stages | output | NSTG | Per-stage invalidate of younger front-end stages |

## Verification
The in-module assertions check the timing relations on every cycle. The redirect and the flush always rise together. A redirect only follows a valid branch that the dynamic predictor missed. An indirect or non-branch instruction never produces one. The direction rule itself, including the equal-target corner, the disabled backward rule and the wrap-around of the sequential address, can only be shown by the bench. The bench compares each output against a model of the rule, over randomised kinds, addresses and targets and over directed edge cases.

// File: rtl/static_dir_predictor.sv
module static_dir_predictor #(
  parameter int AW   = 32,
  parameter int LW   = 4,
  parameter int NSTG = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [1:0]      dec_kind,
  input  logic [AW-1:0]   dec_pc,
  input  logic [LW-1:0]   dec_len,
  input  logic [AW-1:0]   dec_target,
  input  logic            dyn_hit,
  input  logic            bwd_rule_en,
  output logic            sp_valid,
  output logic            sp_taken,
  output logic            redirect_valid,
  output logic [AW-1:0]   redirect_pc,
  output logic [AW-1:0]   seq_pc,
  output logic [NSTG-1:0] flush_stages
);
  localparam logic [1:0] K_NONE   = 2'b00;
  localparam logic [1:0] K_UNCOND = 2'b01;
  localparam logic [1:0] K_COND   = 2'b10;

  logic is_branch, engage, backward, taken_d;

  assign is_branch = dec_kind != K_NONE;
  assign engage    = dec_valid && is_branch && !dyn_hit;
  assign backward  = dec_target <= dec_pc;
  assign taken_d   = (dec_kind == K_UNCOND) ||
                     (dec_kind == K_COND && bwd_rule_en && backward);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_valid       <= 1'b0;
      sp_taken       <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      seq_pc         <= '0;
      flush_stages   <= '0;
    end else begin
      sp_valid       <= engage;
      sp_taken       <= engage && taken_d;
      redirect_valid <= engage && taken_d;
      redirect_pc    <= (engage && taken_d) ? dec_target : '0;
      seq_pc         <= dec_pc + AW'(dec_len);
      flush_stages   <= (engage && taken_d) ? '1 : '0;
    end
  end

  assert_flush_tracks_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_stages != '0) == redirect_valid);

  assert_redirect_needs_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dyn_hit) |-> !redirect_valid && !sp_valid);

  assert_idle_no_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> !redirect_valid && !sp_valid);

  assert_indirect_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'b11) |=> !redirect_valid);

  assert_taken_implies_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> sp_valid && sp_taken);
endmodule

// File: tb/static_dir_predictor_bench.sv
module static_dir_predictor_bench;
  localparam int AW = 32, LW = 4, NSTG = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dec_valid = 1'b0, dyn_hit = 1'b0, bwd_rule_en = 1'b1;
  logic [1:0] dec_kind = 2'b00;
  logic [AW-1:0] dec_pc = '0, dec_target = '0;
  logic [LW-1:0] dec_len = '0;
  logic sp_valid, sp_taken, redirect_valid;
  logic [AW-1:0] redirect_pc, seq_pc;
  logic [NSTG-1:0] flush_stages;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  static_dir_predictor #(.AW(AW), .LW(LW), .NSTG(NSTG)) u_static_dir_predictor (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
    .dec_pc(dec_pc), .dec_len(dec_len), .dec_target(dec_target), .dyn_hit(dyn_hit),
    .bwd_rule_en(bwd_rule_en), .sp_valid(sp_valid), .sp_taken(sp_taken),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .seq_pc(seq_pc),
    .flush_stages(flush_stages));

  function automatic bit exp_taken(input logic [1:0] k, input logic [AW-1:0] pc,
                                   input logic [AW-1:0] tg, input bit bwd);
    if (k == 2'b01) return 1'b1;
    if (k == 2'b10) return bwd && (tg <= pc);
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input bit v, input logic [1:0] k, input logic [AW-1:0] pc,
                       input logic [LW-1:0] len, input logic [AW-1:0] tg,
                       input bit hit, input bit bwd, input string req);
    bit eng, tk;
    dec_valid = v; dec_kind = k; dec_pc = pc; dec_len = len;
    dec_target = tg; dyn_hit = hit; bwd_rule_en = bwd;
    eng = v && k != 2'b00 && !hit;
    tk = eng && exp_taken(k, pc, tg, bwd);
    @(negedge clk);
    chk({req, " sp_valid"}, AW'(sp_valid), AW'(eng));
    chk({req, " sp_taken"}, AW'(sp_taken), AW'(tk));
    chk({req, " redirect"}, AW'(redirect_valid), AW'(tk));
    chk({req, " R10 redirect_pc"}, redirect_pc, tk ? tg : '0);
    chk({req, " R8 flush"}, AW'(flush_stages), tk ? AW'({NSTG{1'b1}}) : '0);
    chk("R10 seq_pc", seq_pc, pc + AW'(len));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    chk("R1 reset redirect", AW'(redirect_valid), '0);
    chk("R1 reset flush", AW'(flush_stages), '0);
    chk("R1 reset sp_valid", AW'(sp_valid), '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release seq_pc", seq_pc, '0);
    chk("R1 after release redirect_pc", redirect_pc, '0);

    apply(1, 2'b01, 32'h1000, 4'd5, 32'h2000, 0, 1, "R2 uncond");
    apply(0, 2'b00, 32'h0, 4'd0, 32'h0, 0, 1, "R8 pulse ends");
    apply(1, 2'b10, 32'h1000, 4'd2, 32'h1001, 0, 1, "R3 fwd");
    apply(1, 2'b10, 32'h1000, 4'd2, 32'h1000, 0, 1, "R4 equal");
    apply(1, 2'b10, 32'h1000, 4'd2, 32'h0F00, 0, 1, "R4 bwd");
    apply(1, 2'b11, 32'h1000, 4'd3, 32'h0100, 0, 1, "R5 indirect");
    apply(1, 2'b01, 32'h1000, 4'd3, 32'h0100, 1, 1, "R6 dyn hit");
    apply(1, 2'b10, 32'h1000, 4'd3, 32'h0100, 1, 1, "R6 dyn hit cond");
    apply(0, 2'b01, 32'h1000, 4'd3, 32'h0100, 0, 1, "R7 invalid");
    apply(1, 2'b00, 32'h1000, 4'd3, 32'h0100, 0, 1, "R7 none");
    apply(1, 2'b10, 32'h1000, 4'd3, 32'h0100, 0, 0, "R9 bwd off");
    apply(1, 2'b10, 32'h1000, 4'd3, 32'h1000, 0, 0, "R9 bwd off equal");
    apply(1, 2'b11, 32'hFFFF_FFFE, 4'd5, 32'h0, 0, 1, "R10 wrap");
    apply(1, 2'b01, 32'h10, 4'd1, 32'h20, 0, 1, "R8 back2back a");
    apply(1, 2'b10, 32'h40, 4'd1, 32'h30, 0, 1, "R8 back2back b");

    for (int i = 0; i < 2000; i++) begin
      logic [AW-1:0] pc, tg;
      pc = $urandom;
      tg = ($urandom % 3 == 0) ? pc - AW'($urandom % 64) : $urandom;
      apply(($urandom % 8) != 0, 2'($urandom), pc, LW'($urandom), tg,
            ($urandom % 4) == 0, ($urandom % 5) != 0, "R2-R9 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule